// File: doc/BRIEF.md
# Open-drain two-wire bus bit engine

This block is the lowest layer of a single-master two-wire serial bus controller. It owns the clock and data lines of an I2C bus, both modelled as open-drain: the block only ever pulls a line low through an output enable, and a released line floats high through the external pull-up. A transaction controller above it issues one primitive at a time. The primitives are: bus start (which also serves as a repeated start), bus stop, byte transmit with acknowledge sampling, byte receive with a chosen acknowledge reply, and bus release. The block turns each primitive into a fixed list of single-line moves.

Each move is one step of `2*D+1` system clocks. D is the settle count captured when the command is accepted. The line changes, or the data line is sampled, in the middle of the step, so D idle clocks come before each change and D come after it. After every transmitted bit the data line is released high, so the bus always sits in the same state between bits: clock low, data high. From that state a start works as a repeated start, and a receive can begin. The data value that is sampled is the wired-AND of the block's own drive and an external pull-down input that represents the slave devices.

A new command is taken only while the engine is idle. Completion is signalled by a one-cycle pulse. The received byte and the acknowledge status are held until the next command that updates them.

Top module: `i2c_bitbang_engine`

## Requirements
- R1: After reset both lines are released (`scl_oe`=0, `sda_oe`=0), `cmd_ready`=1, `done`=0, `rx_data`=0 and `ack_err`=0.
- R2: Every line move is one step of 2*D+1 clocks, where D is `delay_cfg` captured on the accepting edge. The move takes effect on the edge that ends the step's (D+1)-th clock, and `delay_cfg` changes during a command have no effect on it.
- R3: Command code 1 (start) releases the clock, then pulls the data line low, then pulls the clock low, then releases the data line, one step per move.
- R4: Command code 2 (stop) pulls the data line low, then releases the clock, then releases the data line.
- R5: Command code 5 (release) releases the clock, then releases the data line.
- R6: Command code 3 (transmit) sends `cmd_data` most significant bit first. Each bit takes four steps: put the bit on the data line (1 = released), release the clock, pull the clock low, release the data line. A ninth clock follows in three steps (release the clock, sample data, pull the clock low). `ack_err` becomes the sampled level: 0 means acknowledged, 1 means not acknowledged.
- R7: Command code 4 (receive) shifts in eight bits most significant first. Each bit takes three steps: release the clock, sample data, pull the clock low. It then sends a ninth bit in four steps with value `cmd_nack` (0 = acknowledge, 1 = not acknowledge), and the assembled byte appears on `rx_data`.
- R8: `done` pulses for exactly one cycle, in the cycle after the edge that ends the last step. `cmd_ready` returns to 1 in that same cycle. `rx_data` changes only at the completion of a receive and `ack_err` only at the completion of a transmit.
- R9: A command is accepted only when `cmd_valid` is high while `cmd_ready` is high. A `cmd_valid` during a command, or one carrying code 0, 6 or 7, has no effect on the lines, on `done` or on `cmd_ready`.
- R10: The sampled data value is high only if the block releases the data line and `sda_pull` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| delay_cfg | input | DLY_W | Settle count D, captured when a command is accepted |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (1 start, 2 stop, 3 transmit, 4 receive, 5 release) |
| cmd_data | input | 8 | Byte to transmit |
| cmd_nack | input | 1 | Receive reply: 0 acknowledge, 1 not acknowledge |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Last received byte |
| ack_err | output | 1 | Last transmit was not acknowledged |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |
| sda_pull | input | 1 | External device pulling the data line low |

## Verification
A wrong step counter, bit counter or settle count shows up at the line enables within one step of the fault. The move lands on the wrong clock, or the move sequence goes out of order, and the per-clock comparison against the reference catches it at once. A corrupted shift register shows up at `rx_data` or `ack_err` in the completion cycle of that command. A lost or stuck busy flag shows up as `done` or `cmd_ready` out of place.

// File: rtl/i2c_bitbang_engine.sv
module i2c_bitbang_engine #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] delay_cfg,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  input  logic             cmd_nack,
  output logic             cmd_ready,
  output logic             done,
  output logic [7:0]       rx_data,
  output logic             ack_err,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_pull
);
  localparam logic [2:0] OP_START = 3'd1, OP_STOP = 3'd2, OP_SEND = 3'd3,
                         OP_RECV = 3'd4, OP_REL = 3'd5;
  localparam logic [1:0] K_SCL = 2'd0, K_SDA = 2'd1, K_SMP = 2'd2;

  logic             busy, nack_q;
  logic [2:0]       op_q;
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W:0]   tcnt;
  logic [3:0]       bitn;
  logic [1:0]       sub;
  logic [7:0]       shreg;
  logic [1:0]       kind;
  logic             val, last, bit_end, txb;

  wire sda_line = ~sda_oe & ~sda_pull;
  wire op_ok    = (cmd_op >= OP_START) && (cmd_op <= OP_REL);
  wire act_now  = (tcnt == {1'b0, dly_q});
  wire step_end = (tcnt == {dly_q, 1'b0});
  assign cmd_ready = ~busy;

  always_comb begin
    kind = K_SCL; val = 1'b1; last = 1'b0; bit_end = 1'b0; txb = 1'b0;
    case (op_q)
      OP_START: begin
        last = (sub == 2'd3);
        case (sub)
          2'd0: begin kind = K_SCL; val = 1'b1; end
          2'd1: begin kind = K_SDA; val = 1'b0; end
          2'd2: begin kind = K_SCL; val = 1'b0; end
          default: begin kind = K_SDA; val = 1'b1; end
        endcase
      end
      OP_STOP: begin
        last = (sub == 2'd2);
        case (sub)
          2'd0: begin kind = K_SDA; val = 1'b0; end
          2'd1: begin kind = K_SCL; val = 1'b1; end
          default: begin kind = K_SDA; val = 1'b1; end
        endcase
      end
      OP_REL: begin
        last = (sub == 2'd1);
        kind = (sub == 2'd0) ? K_SCL : K_SDA;
      end
      OP_SEND, OP_RECV: begin
        txb = (op_q == OP_SEND) ^ (bitn == 4'd8);
        if (txb) begin
          bit_end = (sub == 2'd3);
          case (sub)
            2'd0: begin kind = K_SDA; val = (op_q == OP_SEND) ? shreg[7] : nack_q; end
            2'd1: begin kind = K_SCL; val = 1'b1; end
            2'd2: begin kind = K_SCL; val = 1'b0; end
            default: begin kind = K_SDA; val = 1'b1; end
          endcase
        end else begin
          bit_end = (sub == 2'd2);
          case (sub)
            2'd0: begin kind = K_SCL; val = 1'b1; end
            2'd1: kind = K_SMP;
            default: begin kind = K_SCL; val = 1'b0; end
          endcase
        end
        last = bit_end && (bitn == 4'd8);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; nack_q <= 1'b0; op_q <= '0; dly_q <= '0; tcnt <= '0;
      bitn <= '0; sub <= '0; shreg <= '0; done <= 1'b0; rx_data <= '0;
      ack_err <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid && op_ok) begin
          busy <= 1'b1; op_q <= cmd_op; nack_q <= cmd_nack; dly_q <= delay_cfg;
          shreg <= cmd_data; tcnt <= '0; bitn <= '0; sub <= '0;
        end
      end else begin
        if (act_now) begin
          case (kind)
            K_SCL:   scl_oe <= ~val;
            K_SDA:   sda_oe <= ~val;
            default: shreg <= {shreg[6:0], sda_line};
          endcase
        end
        if (step_end) begin
          tcnt <= '0;
          if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (op_q == OP_SEND) ack_err <= shreg[0];
            if (op_q == OP_RECV) rx_data <= shreg;
          end else if (bit_end) begin
            bitn <= bitn + 4'd1;
            sub  <= '0;
            if (op_q == OP_SEND) shreg <= {shreg[6:0], 1'b0};
          end else begin
            sub <= sub + 2'd1;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end
endmodule

module i2c_bitbang_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic cmd_ready,
  input logic done
);
  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n) done |-> cmd_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_scl_busy_r9: assert property (@(posedge clk) disable iff (!rst_n) !$stable(scl_oe) |-> !$past(cmd_ready));
  p_sda_busy_r9: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !$past(cmd_ready));
  p_one_line_r2: assert property (@(posedge clk) disable iff (!rst_n) !$stable(scl_oe) |-> $stable(sda_oe));
endmodule

bind i2c_bitbang_engine i2c_bitbang_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .cmd_ready(cmd_ready), .done(done)
);

// File: tb/i2c_bitbang_engine_test.sv
module i2c_bitbang_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] delay_cfg = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_data = '0;
  logic cmd_nack = 1'b0, sda_pull = 1'b0;
  logic cmd_ready, done, ack_err, scl_oe, sda_oe;
  logic [7:0] rx_data;

  always #2.5 clk = ~clk;

  i2c_bitbang_engine #(.DLY_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .delay_cfg(delay_cfg), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_nack(cmd_nack),
    .cmd_ready(cmd_ready), .done(done), .rx_data(rx_data), .ack_err(ack_err),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_pull(sda_pull)
  );

  int runs = 0, fails = 0, cyc = 0;
  bit finished = 0;
  bit m_scl = 0, m_sda = 0, cur_pull = 0, m_smp = 0;
  logic [7:0] exp_rx = 0;
  bit exp_ack = 0;
  bit q_pull[$];
  logic [3:0] q_exp[$];

  task automatic check(bit ok, string tag, int act, int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(bit dn);
    q_pull.push_back(cur_pull);
    q_exp.push_back({m_scl, m_sda, dn, dn});
  endtask

  // kind 0: clock line, 1: data line, 2: sample; v is the line level (1 = released)
  task automatic mstep(int kind, bit v, int d);
    for (int t = 0; t <= d; t++) push(1'b0);
    if (kind == 0) m_scl = ~v;
    else if (kind == 1) m_sda = ~v;
    else m_smp = !m_sda && !cur_pull;
    for (int t = 0; t < d; t++) push(1'b0);
  endtask

  task automatic txbit(bit v, int d);
    cur_pull = 0;
    mstep(1, v, d); mstep(0, 1, d); mstep(0, 0, d); mstep(1, 1, d);
  endtask

  task automatic rxbit(bit pull, int d);
    cur_pull = pull;
    mstep(0, 1, d); mstep(2, 0, d); mstep(0, 0, d);
    cur_pull = 0;
  endtask

  task automatic build(int op, logic [7:0] data, bit nack, bit slave_pull, int d);
    logic [7:0] acc;
    acc = 0;
    case (op)
      1: begin mstep(0, 1, d); mstep(1, 0, d); mstep(0, 0, d); mstep(1, 1, d); end
      2: begin mstep(1, 0, d); mstep(0, 1, d); mstep(1, 1, d); end
      5: begin mstep(0, 1, d); mstep(1, 1, d); end
      3: begin
        for (int i = 7; i >= 0; i--) txbit(data[i], d);
        rxbit(slave_pull, d);
        exp_ack = m_smp;
      end
      4: begin
        for (int i = 7; i >= 0; i--) begin
          rxbit(~data[i], d);
          acc = {acc[6:0], m_smp};
        end
        txbit(nack, d);
        exp_rx = acc;
      end
      default: ;
    endcase
    push(1'b1);
  endtask

  task automatic run_cmd(int op, logic [7:0] data, bit nack, bit slave_pull, int d,
                         int poke, string tag);
    @(negedge clk);
    check(cmd_ready == 1'b1, {tag, " ready before issue"}, cmd_ready, 1);
    sda_pull = 0; cmd_valid = 1; cmd_op = op[2:0]; cmd_data = data; cmd_nack = nack;
    delay_cfg = d[7:0];
    build(op, data, nack, slave_pull, d);
    @(negedge clk);
    cmd_valid = 0;
    delay_cfg = 8'(d + 3);
    for (int k = 0; q_exp.size() > 0; k++) begin
      logic [3:0] e;
      bit pl;
      e = q_exp.pop_front();
      pl = q_pull.pop_front();
      sda_pull = pl;
      check({scl_oe, sda_oe, done, cmd_ready} == e, {tag, " lines/done/ready"},
            {scl_oe, sda_oe, done, cmd_ready}, e);
      if (e[1]) begin
        check(rx_data == exp_rx, {tag, " rx_data"}, rx_data, exp_rx);
        check(ack_err == exp_ack, {tag, " ack_err"}, ack_err, exp_ack);
      end
      if (k == poke) begin cmd_valid = 1; cmd_op = 3'd1; end
      else cmd_valid = 0;
      @(negedge clk);
    end
    sda_pull = 0;
  endtask

  task automatic idle_chk(int n, string tag);
    for (int i = 0; i < n; i++) begin
      check({scl_oe, sda_oe, done, cmd_ready} == {m_scl, m_sda, 2'b01}, tag,
            {scl_oe, sda_oe, done, cmd_ready}, {m_scl, m_sda, 2'b01});
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({scl_oe, sda_oe, done, cmd_ready} == 4'b0001, "R1 reset outputs",
          {scl_oe, sda_oe, done, cmd_ready}, 1);
    check(rx_data == 0 && ack_err == 0, "R1 reset results", {rx_data, ack_err}, 0);
    rst_n = 1;
    @(negedge clk);
    run_cmd(5, 8'h00, 0, 0, 2, -1, "R5 release");
    run_cmd(1, 8'h00, 0, 0, 1, -1, "R3 start");
    run_cmd(3, 8'hA5, 0, 1, 1, -1, "R6 send acked");
    run_cmd(3, 8'h3C, 0, 0, 0, -1, "R6 send nacked R8 rx held");
    run_cmd(1, 8'h00, 0, 0, 1, -1, "R3 repeated start");
    run_cmd(4, 8'h96, 0, 0, 2, -1, "R7 recv ack R2 delay latched");
    run_cmd(4, 8'h5A, 1, 0, 0, -1, "R7 recv nack R10 wired-and");
    run_cmd(3, 8'hC3, 0, 1, 1, 7, "R9 busy poke ignored");
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd6;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd0;
    @(negedge clk);
    cmd_valid = 0;
    idle_chk(6, "R9 undefined code ignored");
    run_cmd(2, 8'h00, 0, 0, 3, -1, "R4 stop");
    run_cmd(1, 8'h00, 0, 0, 0, -1, "R3 start zero delay");
    run_cmd(4, 8'hFF, 0, 0, 1, -1, "R7 recv all ones");
    run_cmd(2, 8'h00, 0, 0, 0, -1, "R4 stop zero delay");
    run_cmd(5, 8'h00, 0, 0, 0, -1, "R5 release zero delay");
    idle_chk(4, "R8 idle after done");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule